// File: doc/BRIEF.md
# Fixed-Point Reciprocal Unit (Quadratic Seed plus One Newton Step)

The block takes a normalized unsigned fixed-point divisor d in [1, 2) and returns 1/d to 6m fractional bits. The default is m = 4, which gives a 24-bit fraction. The top m fraction bits of d select an interval. A small coefficient table, computed at elaboration time, supplies three coefficients for that interval. A degree-2 polynomial in the remaining low bits of d produces a seed good to roughly 3m bits. A single Newton step, x' = x·(2 − d·x), then doubles the number of correct bits.

A divisor enters through a valid/ready handshake and the result leaves through another one. Exactly one operation is in flight at a time. The sequence is fixed: one cycle evaluates the polynomial, and two cycles perform the Newton step. Both Newton products share one multiplier by default. Intermediate products are truncated toward zero at fixed binary points, with a few guard bits kept beyond the result precision.

Top module: `rcp_unit`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: in_ready is 1 only while the unit is idle. It is 0 from the cycle after an input is accepted until the result has been taken.
- R3: An input is accepted when in_valid and in_ready are both 1 at a rising edge. If that happens in cycle n, out_valid is 0 in cycles n+1 to n+3 and 1 in cycle n+4.
- R4: in_d and out_recip are unsigned Q1.24 values: bit 24 has weight 1 and bits 23:0 are the fraction. For any in_d with bit 24 set, out_recip differs from the real value 1/d by at most 2 units of 2^-24.
- R5: out_recip never exceeds 1.0: when bit 24 is set, bits 23:0 are zero. For d = 1.0 the result is within 2 units of 2^-24 of 1.0.
- R6: For the largest divisor, d = 2 − 2^-24, the result is within 2 units of 2^-24 of 1/d (about 0.5).
- R7: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_recip does not change.
- R8: in_valid and in_d have no effect while in_ready is 0. The result depends only on the divisor that was accepted.
- R9: In the cycle after out_valid and out_ready are both 1, in_ready is 1 and out_valid is 0.
- R10: The coefficient interval is selected by in_d[23:20]. The lowest, middle and highest divisor of every one of the 16 intervals meet the R4 accuracy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Divisor offered |
| in_ready | output | 1 | Unit idle; an offered divisor is taken at the next edge |
| in_d | input | 25 | Divisor, Q1.24, bit 24 must be 1 |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_recip | output | 25 | Reciprocal, Q1.24 |

## Verification
Two functions can meet in the same cycle: holding a finished result for a stalled consumer, and a new divisor being offered at the input. The bench provokes this by keeping in_valid high with a different divisor for the whole computation and through several stalled result cycles. It judges the outcome by requiring in_ready to stay low, out_recip to stay frozen, and the delivered value to be the reciprocal of the first divisor. It then checks that the release cycle returns the unit to idle with no result pending.

// File: rtl/rcp_pkg.sv
package rcp_pkg;

    localparam int RCP_M = 4;
    localparam int RCP_G = 2;
    // scale used while building coefficients at elaboration
    localparam int COEF_SCL = 40;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POLY,
        ST_NR1,
        ST_NR2,
        ST_DONE
    } rcp_state_e;

    // Coefficient for interval idx, expanded about the interval midpoint and
    // re-centred on the interval start. sel 0 -> constant term, 1 -> magnitude
    // of linear term, 2 -> quadratic term. Rounded to nearest, saturated.
    function automatic longint unsigned rcp_coef(int sel, int idx, int m, int g);
        longint unsigned c;
        longint unsigned i1;
        longint unsigned i2;
        longint unsigned i3;
        longint unsigned v;
        longint unsigned mx;
        int f;
        int sh;
        c  = (64'd1 << (m + 1)) + 64'(2 * idx + 1);
        i1 = (64'd1 << (COEF_SCL + m + 1)) / c;
        i2 = (i1 << (m + 1)) / c;
        i3 = (i2 << (m + 1)) / c;
        case (sel)
            0: begin
                v = i1 + (i2 >> (m + 1)) + (i3 >> (2 * m + 2));
                f = 3 * m + g;
            end
            1: begin
                v = i2 + (i3 >> m);
                f = 2 * m + g;
            end
            default: begin
                v = i3;
                f = m + g;
            end
        endcase
        sh = COEF_SCL - f;
        v  = (v + (64'd1 << (sh - 1))) >> sh;
        mx = (64'd1 << f) - 64'd1;
        if (v > mx) v = mx;
        return v;
    endfunction

endpackage

// File: rtl/rcp_coef_rom.sv
module rcp_coef_rom #(
    parameter int M = rcp_pkg::RCP_M,
    parameter int G = rcp_pkg::RCP_G
) (
    input  logic [M-1:0]       idx,
    output logic [3*M+G-1:0]   a0,
    output logic [2*M+G-1:0]   a1,
    output logic [M+G-1:0]     a2
);
    localparam int ENT = 1 << M;
    localparam int A0W = 3 * M + G;
    localparam int A1W = 2 * M + G;
    localparam int A2W = M + G;

    logic [A0W-1:0] tab0 [ENT];
    logic [A1W-1:0] tab1 [ENT];
    logic [A2W-1:0] tab2 [ENT];

    for (genvar i = 0; i < ENT; i++) begin : g_ent
        localparam logic [A0W-1:0] K0 = A0W'(rcp_pkg::rcp_coef(0, i, M, G));
        localparam logic [A1W-1:0] K1 = A1W'(rcp_pkg::rcp_coef(1, i, M, G));
        localparam logic [A2W-1:0] K2 = A2W'(rcp_pkg::rcp_coef(2, i, M, G));
        assign tab0[i] = K0;
        assign tab1[i] = K1;
        assign tab2[i] = K2;
    end

    assign a0 = tab0[idx];
    assign a1 = tab1[idx];
    assign a2 = tab2[idx];
endmodule

// File: rtl/rcp_seed_poly.sv
module rcp_seed_poly #(
    parameter int M = rcp_pkg::RCP_M,
    parameter int G = rcp_pkg::RCP_G
) (
    input  logic [5*M-1:0]     xl,
    input  logic [3*M+G-1:0]   a0,
    input  logic [2*M+G-1:0]   a1,
    input  logic [M+G-1:0]     a2,
    output logic [6*M+G:0]     seed
);
    localparam int FD   = 6 * M;
    localparam int SF   = FD + G;
    localparam int SW   = SF + 1;
    localparam int A0W  = 3 * M + G;
    localparam int A1W  = 2 * M + G;
    localparam int A2W  = M + G;
    localparam int PW   = 2 * SW + 2;
    localparam int SQSH = 2 * FD - SF;
    localparam int L1SH = A1W + FD - SF;

    logic [PW-1:0] sq_full;
    logic [PW-1:0] sq_s;
    logic [PW-1:0] p2;
    logic [PW-1:0] p1;
    logic [PW-1:0] term0;
    logic [PW-1:0] term1;
    logic [PW-1:0] term2;

    always_comb begin
        sq_full = PW'(xl) * PW'(xl);          // weight 2^-2FD
        sq_s    = sq_full >> SQSH;             // weight 2^-SF
        p2      = PW'(a2) * sq_s;              // weight 2^-(SF+A2W)
        term2   = p2 >> A2W;
        p1      = PW'(a1) * PW'(xl);           // weight 2^-(A1W+FD)
        term1   = p1 >> L1SH;
        term0   = PW'(a0) << (SF - A0W);
        seed    = SW'(term0 - term1 + term2);
    end
endmodule

// File: rtl/rcp_nr_step.sv
module rcp_nr_step #(
    parameter int M         = rcp_pkg::RCP_M,
    parameter int G         = rcp_pkg::RCP_G,
    parameter bit SHARE_MUL = 1'b1
) (
    input  logic [6*M:0]       d,
    input  logic [6*M+G:0]     seed,
    input  logic [6*M+G+1:0]   corr,
    input  logic               second,
    output logic [6*M+G+1:0]   corr_next,
    output logic [6*M:0]       recip_next
);
    localparam int FD  = 6 * M;
    localparam int SF  = FD + G;
    localparam int SW  = SF + 1;
    localparam int CW  = SF + 2;
    localparam int RW  = FD + 1;
    localparam int PW  = 2 * SW + 2;
    localparam int RSH = 2 * SF - FD;
    localparam logic [PW-1:0] TWO = PW'(2) << SF;

    logic [PW-1:0] prod_dx;
    logic [PW-1:0] prod_xc;

    if (SHARE_MUL) begin : g_shared
        logic [PW-1:0] opa;
        logic [PW-1:0] opb;
        logic [PW-1:0] prod;
        assign opa     = second ? PW'(seed) : PW'(d);
        assign opb     = second ? PW'(corr) : PW'(seed);
        assign prod    = opa * opb;
        assign prod_dx = prod;
        assign prod_xc = prod;
    end else begin : g_split
        assign prod_dx = PW'(d) * PW'(seed);
        assign prod_xc = second ? PW'(seed) * PW'(corr) : '0;
    end

    // d*x truncated to SF bits, then two's-complement subtraction from 2
    assign corr_next  = CW'(TWO - (prod_dx >> FD));
    // x*(2-d*x) truncated to the result fraction
    assign recip_next = RW'(prod_xc >> RSH);
endmodule

// File: rtl/rcp_ctrl.sv
module rcp_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic out_valid,
    output logic ld_d,
    output logic ld_seed,
    output logic ld_corr,
    output logic ld_res,
    output logic nr_second
);
    import rcp_pkg::*;

    rcp_state_e st_q;
    rcp_state_e st_d;

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE: if (in_valid) st_d = ST_POLY;
            ST_POLY: st_d = ST_NR1;
            ST_NR1:  st_d = ST_NR2;
            ST_NR2:  st_d = ST_DONE;
            ST_DONE: if (out_ready) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    assign in_ready  = (st_q == ST_IDLE);
    assign ld_d      = (st_q == ST_IDLE) && in_valid;
    assign ld_seed   = (st_q == ST_POLY);
    assign ld_corr   = (st_q == ST_NR1);
    assign ld_res    = (st_q == ST_NR2);
    assign nr_second = (st_q == ST_NR2);
    assign out_valid = (st_q == ST_DONE);
endmodule

// File: rtl/rcp_unit.sv
module rcp_unit #(
    parameter int M         = rcp_pkg::RCP_M,
    parameter int G         = rcp_pkg::RCP_G,
    parameter bit SHARE_MUL = 1'b1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [6*M:0]   in_d,
    output logic           out_valid,
    input  logic           out_ready,
    output logic [6*M:0]   out_recip
);
    localparam int FD  = 6 * M;
    localparam int DW  = FD + 1;
    localparam int XLW = FD - M;
    localparam int SF  = FD + G;
    localparam int SW  = SF + 1;
    localparam int CW  = SF + 2;
    localparam int RW  = FD + 1;

    logic          ld_d;
    logic          ld_seed;
    logic          ld_corr;
    logic          ld_res;
    logic          nr_second;
    logic [DW-1:0] d_q;
    logic [SW-1:0] seed_q;
    logic [SW-1:0] seed_c;
    logic [CW-1:0] corr_q;
    logic [CW-1:0] corr_c;
    logic [RW-1:0] res_q;
    logic [RW-1:0] res_c;
    logic [3*M+G-1:0] a0;
    logic [2*M+G-1:0] a1;
    logic [M+G-1:0]   a2;

    rcp_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .ld_d      (ld_d),
        .ld_seed   (ld_seed),
        .ld_corr   (ld_corr),
        .ld_res    (ld_res),
        .nr_second (nr_second)
    );

    rcp_coef_rom #(.M(M), .G(G)) u_rom (
        .idx (d_q[FD-1 -: M]),
        .a0  (a0),
        .a1  (a1),
        .a2  (a2)
    );

    rcp_seed_poly #(.M(M), .G(G)) u_poly (
        .xl   (d_q[XLW-1:0]),
        .a0   (a0),
        .a1   (a1),
        .a2   (a2),
        .seed (seed_c)
    );

    rcp_nr_step #(.M(M), .G(G), .SHARE_MUL(SHARE_MUL)) u_nr (
        .d          (d_q),
        .seed       (seed_q),
        .corr       (corr_q),
        .second     (nr_second),
        .corr_next  (corr_c),
        .recip_next (res_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            d_q    <= '0;
            seed_q <= '0;
            corr_q <= '0;
            res_q  <= '0;
        end else begin
            if (ld_d)    d_q    <= in_d;
            if (ld_seed) seed_q <= seed_c;
            if (ld_corr) corr_q <= corr_c;
            if (ld_res)  res_q  <= res_c;
        end
    end

    assign out_recip = res_q;
endmodule

// File: rtl/rcp_unit_chk.sv
module rcp_unit_chk #(
    parameter int M = rcp_pkg::RCP_M
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         in_ready,
    input logic         out_valid,
    input logic         out_ready,
    input logic [6*M:0] out_recip
);
    localparam int FD = 6 * M;

    // R1
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (in_ready && !out_valid));

    // R2
    a_r2_ready_excl: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid));

    // R3
    a_r3_latency: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && in_valid && in_ready, 4) |-> $rose(out_valid));

    // R5
    a_r5_ceiling: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_recip[FD]) |-> (out_recip[FD-1:0] == '0));

    // R7
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_recip)));

    // R9
    a_r9_release: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> (in_ready && !out_valid));
endmodule

bind rcp_unit rcp_unit_chk #(.M(M)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_recip (out_recip)
);

// File: tb/tb_rcp_unit.sv
`timescale 1ns/1ps
module tb_rcp_unit;
    localparam int M  = 4;
    localparam int FD = 6 * M;
    localparam int DW = FD + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_d = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [DW-1:0] out_recip;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rcp_unit dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_d      (in_d),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_recip (out_recip)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // R4 accuracy against real 1/d, plus R5 ceiling on every result
    task automatic chk_acc(input string req, input logic [DW-1:0] d, input logic [DW-1:0] r);
        real dr, ex, got, err;
        dr  = real'(d) / (2.0 ** FD);
        ex  = 1.0 / dr;
        got = real'(r) / (2.0 ** FD);
        err = (got - ex) * (2.0 ** FD);
        if (err < 0.0) err = -err;
        checks++;
        if (err > 2.0) begin
            errors++;
            $display("FAIL %s d=%h: actual %h (%f) expected %f, err %f ulp", req, d, r, got, ex, err);
        end
        chk(!(r[FD] && (r[FD-1:0] != '0)), "R5", "above 1.0", longint'(r), longint'(1) << FD);
    endtask

    // One operation; hold = stalled result cycles; noisy keeps a foreign divisor offered
    task automatic run_op(input logic [DW-1:0] d, input int hold, input bit noisy,
                          output logic [DW-1:0] res);
        @(negedge clk);
        chk(in_ready === 1'b1, "R2", "in_ready while idle", longint'(in_ready), 1);
        in_valid = 1'b1;
        in_d     = d;
        @(negedge clk);
        if (noisy) in_d = d ^ 25'h0A5A5A;
        else       in_valid = 1'b0;
        for (int k = 1; k <= 3; k++) begin
            chk(out_valid === 1'b0, "R3", "early out_valid", longint'(out_valid), 0);
            chk(in_ready === 1'b0, "R2", "in_ready while busy", longint'(in_ready), 0);
            @(negedge clk);
        end
        chk(out_valid === 1'b1, "R3", "out_valid at n+4", longint'(out_valid), 1);
        chk(in_ready === 1'b0, "R2", "in_ready with result", longint'(in_ready), 0);
        res = out_recip;
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            chk(out_valid === 1'b1 && out_recip === res, "R7", "stalled result",
                longint'(out_recip), longint'(res));
            chk(in_ready === 1'b0, "R8", "input taken while stalled", longint'(in_ready), 0);
        end
        out_ready = 1'b1;
        in_valid  = 1'b0;
        @(negedge clk);
        out_ready = 1'b0;
        chk(in_ready === 1'b1 && out_valid === 1'b0, "R9", "return to idle",
            longint'({in_ready, out_valid}), 2);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(in_ready === 1'b1 && out_valid === 1'b0, "R1", "reset state",
            longint'({in_ready, out_valid}), 2);
    endtask

    task automatic t_edges;
        logic [DW-1:0] r;
        run_op({1'b1, 24'h000000}, 0, 1'b0, r);
        chk_acc("R5", {1'b1, 24'h000000}, r);
        run_op({1'b1, 24'hFFFFFF}, 0, 1'b0, r);
        chk_acc("R6", {1'b1, 24'hFFFFFF}, r);
    endtask

    task automatic t_sweep;
        logic [DW-1:0] r;
        logic [DW-1:0] d;
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 3; j++) begin
                d = {1'b1, 4'(i), (j == 0) ? 20'h00000 : (j == 1) ? 20'h80000 : 20'hFFFFF};
                run_op(d, 0, 1'b0, r);
                chk_acc("R10", d, r);
            end
        end
    endtask

    task automatic t_random;
        logic [DW-1:0] r;
        logic [DW-1:0] d;
        for (int i = 0; i < 60; i++) begin
            d = {1'b1, 24'($urandom)};
            run_op(d, 0, 1'b0, r);
            chk_acc("R4", d, r);
        end
    endtask

    task automatic t_stall_noisy;
        logic [DW-1:0] r;
        run_op({1'b1, 24'h3C0F11}, 4, 1'b0, r);
        chk_acc("R7", {1'b1, 24'h3C0F11}, r);
        run_op({1'b1, 24'hA18C44}, 5, 1'b1, r);
        chk_acc("R8", {1'b1, 24'hA18C44}, r);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R3 watchdog: cycles %0d expected below %0d", 200000, 200000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd13));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_edges();
        t_sweep();
        t_random();
        t_stall_noisy();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule